// File: doc/BRIEF.md
# Threaded-Code Inner Interpreter Sequencer

This block is the control sequencer at the centre of a 16-bit stack processor that runs threaded code. It supports four dispatch operations: advance along a thread (NEXT), call a colon-style word (ENTER), return from one (EXIT), and run a word whose address sits on the parameter stack (EXECUTE). It holds the instruction pointer (IP), the word register (W), the program counter (PC) and the two stack pointers (RSP for the return stack, PSP for the parameter stack). It reaches a byte-addressed memory of 16-bit cells through a synchronous read port and a write port. When a sequence completes, it raises `done` for one cycle and offers the final PC to the primitive-execution logic.

A mode input selects between two dispatch styles. In direct-threaded mode, the word address is itself the location of machine code, so PC takes the value of W. In indirect-threaded mode, the first cell of every word holds the address of its machine code, so the block makes one more memory read from W to get PC. In that mode the body of a colon word starts `ITC_BODY_CELLS` cells after its address.

The controller walks through these states. ST_IDLE waits for `start`. ST_RPUSH writes IP below the return-stack top. ST_RPOP_REQ and ST_RPOP_TAKE read IP back from the return stack. ST_PPOP_REQ and ST_PPOP_TAKE read W from the parameter stack. ST_FETCH_REQ and ST_FETCH_TAKE read the next thread cell into W. ST_CODE_REQ and ST_CODE_TAKE read PC through the code field. ST_DONE signals completion. The transitions are:
- ST_IDLE goes to ST_FETCH_REQ on NEXT, ST_RPUSH on ENTER, ST_RPOP_REQ on EXIT and ST_PPOP_REQ on EXECUTE.
- ST_RPUSH goes to ST_FETCH_REQ.
- ST_RPOP_REQ goes to ST_RPOP_TAKE, which goes to ST_FETCH_REQ.
- ST_FETCH_REQ goes to ST_FETCH_TAKE.
- ST_FETCH_TAKE and ST_PPOP_TAKE go to ST_CODE_REQ in indirect mode and to ST_DONE in direct mode.
- ST_PPOP_REQ goes to ST_PPOP_TAKE.
- ST_CODE_REQ goes to ST_CODE_TAKE, which goes to ST_DONE.
- ST_DONE goes back to ST_IDLE.

Top module: `tci_seq`

## Requirements
- R1: While `rst_n` is low, and after its release until the first operation, IP equals `IP_RESET`, RSP equals `RSP_RESET`, PSP equals `PSP_RESET`, W and PC are zero, and `done`, `mem_rd` and `mem_wr` are low.
- R2: `op` is encoded 2'b00 NEXT, 2'b01 ENTER, 2'b10 EXIT, 2'b11 EXECUTE. It is sampled together with `start` only in ST_IDLE. A `start` or `op` value presented while an operation is in progress has no effect.
- R3: NEXT loads W with the cell at address IP and adds 2 to IP. In direct mode, PC then equals W.
- R4: In indirect mode, every sequence that ends with a new W (NEXT, ENTER, EXIT, EXECUTE) loads PC from the cell at address W.
- R5: ENTER writes the current IP to address RSP-2, lowers RSP by 2, and sets IP to W+2 in direct mode or to W+2*`ITC_BODY_CELLS` in indirect mode. It then performs NEXT.
- R6: EXIT loads IP from the cell at address RSP, raises RSP by 2, then performs NEXT. After an ENTER/EXIT pair, RSP is back at its earlier value and the thread resumes after the calling cell.
- R7: EXECUTE loads W from the cell at address PSP and raises PSP by 2. PC is set from W according to the mode. IP and RSP are unchanged.
- R8: `itc_mode` high selects indirect mode. It is captured at the start of each operation, and changes during the operation do not affect it.
- R9: `done` is a one-cycle pulse, and IP, W, PC, RSP and PSP hold their final values when it is high. Counting the clock edge that samples `start` as edge 1, `done` is high after edge 3/5 (direct/indirect) for NEXT, 4/6 for ENTER, 5/7 for EXIT and 3/5 for EXECUTE.
- R10: A read drives the address with `mem_rd` high and uses `mem_rdata` in the following cycle. `mem_rd` and `mem_wr` are never high together, and both are low when the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled in idle only) |
| op | input | 2 | Operation select |
| itc_mode | input | 1 | 1 = indirect-threaded, 0 = direct-threaded |
| mem_addr | output | 16 | Byte address for read or write |
| mem_rd | output | 1 | Read request; data is expected next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data (IP being pushed) |
| mem_rdata | input | 16 | Read data from the previous cycle's request |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 16 | Program counter handed to primitive logic |
| ip_out | output | 16 | Instruction pointer |
| w_out | output | 16 | Word register |
| rsp_out | output | 16 | Return stack pointer |
| psp_out | output | 16 | Parameter stack pointer |

## Verification
The bench builds the block with `CELL_W` 16 and `ITC_BODY_CELLS` 2, and places the reset pointers at IP 0x0400, RSP 0x1000 and PSP 0x0F00. These values put a caller thread, a colon word, a primitive, an exit word and one parameter-stack entry in separate regions of a 4 KiB memory model. As a result, every push, pop, thread fetch and code-field read lands on a distinct cell whose value is known. The same call, primitive and return chain runs in both modes. With a body offset of two cells, an indirect ENTER visibly skips an extra cell that a direct ENTER would land on.

// File: rtl/tci_pkg.sv
package tci_pkg;

    typedef enum logic [1:0] {
        OP_NEXT  = 2'b00,
        OP_ENTER = 2'b01,
        OP_EXIT  = 2'b10,
        OP_EXEC  = 2'b11
    } tci_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RPUSH,
        ST_RPOP_REQ,
        ST_RPOP_TAKE,
        ST_PPOP_REQ,
        ST_PPOP_TAKE,
        ST_FETCH_REQ,
        ST_FETCH_TAKE,
        ST_CODE_REQ,
        ST_CODE_TAKE,
        ST_DONE
    } tci_state_e;

    typedef enum logic [2:0] {
        AS_IP,
        AS_W,
        AS_RSP,
        AS_RSP_PRE,
        AS_PSP
    } tci_asel_e;

    typedef struct packed {
        tci_asel_e asel;
        logic      rd;
        logic      wr;
        logic      ip_body;
        logic      ip_mem;
        logic      ip_step;
        logic      w_mem;
        logic      pc_mem;
        logic      rsp_dec;
        logic      rsp_inc;
        logic      psp_inc;
    } tci_ctl_t;

endpackage

// File: rtl/tci_ctrl.sv
module tci_ctrl
    import tci_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start,
    input  tci_op_e  op_i,
    input  logic     itc_mode,
    output tci_ctl_t ctl,
    output logic     itc_q,
    output logic     busy,
    output logic     done
);

    tci_state_e state_q, state_d;

    // state register and mode capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            itc_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                itc_q <= itc_mode;
            end
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    unique case (op_i)
                        OP_NEXT:  state_d = ST_FETCH_REQ;
                        OP_ENTER: state_d = ST_RPUSH;
                        OP_EXIT:  state_d = ST_RPOP_REQ;
                        OP_EXEC:  state_d = ST_PPOP_REQ;
                        default:  state_d = ST_IDLE;
                    endcase
                end
            end
            ST_RPUSH:      state_d = ST_FETCH_REQ;
            ST_RPOP_REQ:   state_d = ST_RPOP_TAKE;
            ST_RPOP_TAKE:  state_d = ST_FETCH_REQ;
            ST_PPOP_REQ:   state_d = ST_PPOP_TAKE;
            ST_PPOP_TAKE:  state_d = itc_q ? ST_CODE_REQ : ST_DONE;
            ST_FETCH_REQ:  state_d = ST_FETCH_TAKE;
            ST_FETCH_TAKE: state_d = itc_q ? ST_CODE_REQ : ST_DONE;
            ST_CODE_REQ:   state_d = ST_CODE_TAKE;
            ST_CODE_TAKE:  state_d = ST_DONE;
            ST_DONE:       state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ctl      = '0;
        ctl.asel = AS_IP;
        unique case (state_q)
            ST_RPUSH: begin
                ctl.asel    = AS_RSP_PRE;
                ctl.wr      = 1'b1;
                ctl.ip_body = 1'b1;
                ctl.rsp_dec = 1'b1;
            end
            ST_RPOP_REQ: begin
                ctl.asel = AS_RSP;
                ctl.rd   = 1'b1;
            end
            ST_RPOP_TAKE: begin
                ctl.ip_mem  = 1'b1;
                ctl.rsp_inc = 1'b1;
            end
            ST_PPOP_REQ: begin
                ctl.asel = AS_PSP;
                ctl.rd   = 1'b1;
            end
            ST_PPOP_TAKE: begin
                ctl.w_mem   = 1'b1;
                ctl.psp_inc = 1'b1;
                ctl.pc_mem  = !itc_q;
            end
            ST_FETCH_REQ: begin
                ctl.asel = AS_IP;
                ctl.rd   = 1'b1;
            end
            ST_FETCH_TAKE: begin
                ctl.w_mem   = 1'b1;
                ctl.ip_step = 1'b1;
                ctl.pc_mem  = !itc_q;
            end
            ST_CODE_REQ: begin
                ctl.asel = AS_W;
                ctl.rd   = 1'b1;
            end
            ST_CODE_TAKE: begin
                ctl.pc_mem = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assign busy = (state_q != ST_IDLE) && (state_q != ST_DONE);
    assign done = (state_q == ST_DONE);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl.rd && ctl.wr)); // R10

endmodule

// File: rtl/tci_regs.sv
module tci_regs
    import tci_pkg::*;
#(
    parameter int          CELL_W         = 16,
    parameter int          ITC_BODY_CELLS = 2,
    parameter logic [15:0] IP_RESET       = 16'h0400,
    parameter logic [15:0] RSP_RESET      = 16'h1000,
    parameter logic [15:0] PSP_RESET      = 16'h0F00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tci_ctl_t          ctl,
    input  logic              itc_q,
    input  logic [CELL_W-1:0] mem_rdata,
    output logic [CELL_W-1:0] mem_addr,
    output logic [CELL_W-1:0] mem_wdata,
    output logic [CELL_W-1:0] ip_q,
    output logic [CELL_W-1:0] w_q,
    output logic [CELL_W-1:0] pc_q,
    output logic [CELL_W-1:0] rsp_q,
    output logic [CELL_W-1:0] psp_q
);

    localparam int                CELL_BYTES = CELL_W / 8;
    localparam logic [CELL_W-1:0] STEP       = CELL_W'(CELL_BYTES);
    localparam logic [CELL_W-1:0] BODY_DTC   = CELL_W'(CELL_BYTES);
    localparam logic [CELL_W-1:0] BODY_ITC   = CELL_W'(CELL_BYTES * ITC_BODY_CELLS);

    logic [CELL_W-1:0] body_off;
    assign body_off = itc_q ? BODY_ITC : BODY_DTC;

    always_comb begin
        unique case (ctl.asel)
            AS_IP:      mem_addr = ip_q;
            AS_W:       mem_addr = w_q;
            AS_RSP:     mem_addr = rsp_q;
            AS_RSP_PRE: mem_addr = rsp_q - STEP;
            AS_PSP:     mem_addr = psp_q;
            default:    mem_addr = ip_q;
        endcase
    end

    assign mem_wdata = ip_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ip_q  <= CELL_W'(IP_RESET);
            w_q   <= '0;
            pc_q  <= '0;
            rsp_q <= CELL_W'(RSP_RESET);
            psp_q <= CELL_W'(PSP_RESET);
        end else begin
            if (ctl.ip_body)      ip_q <= w_q + body_off;
            else if (ctl.ip_mem)  ip_q <= mem_rdata;
            else if (ctl.ip_step) ip_q <= ip_q + STEP;
            if (ctl.w_mem)   w_q   <= mem_rdata;
            if (ctl.pc_mem)  pc_q  <= mem_rdata;
            if (ctl.rsp_dec) rsp_q <= rsp_q - STEP;
            else if (ctl.rsp_inc) rsp_q <= rsp_q + STEP;
            if (ctl.psp_inc) psp_q <= psp_q + STEP;
        end
    end

    AST_PUSH_BELOW_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.wr |-> (mem_addr == rsp_q - STEP)); // R5

endmodule

// File: rtl/tci_seq.sv
module tci_seq
    import tci_pkg::*;
#(
    parameter int          CELL_W         = 16,
    parameter int          ITC_BODY_CELLS = 2,
    parameter logic [15:0] IP_RESET       = 16'h0400,
    parameter logic [15:0] RSP_RESET      = 16'h1000,
    parameter logic [15:0] PSP_RESET      = 16'h0F00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic              itc_mode,
    output logic [CELL_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [CELL_W-1:0] mem_wdata,
    input  logic [CELL_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic [CELL_W-1:0] pc_out,
    output logic [CELL_W-1:0] ip_out,
    output logic [CELL_W-1:0] w_out,
    output logic [CELL_W-1:0] rsp_out,
    output logic [CELL_W-1:0] psp_out
);

    tci_ctl_t ctl;
    logic     itc_q;

    tci_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .op_i     (tci_op_e'(op)),
        .itc_mode (itc_mode),
        .ctl      (ctl),
        .itc_q    (itc_q),
        .busy     (busy),
        .done     (done)
    );

    tci_regs #(
        .CELL_W         (CELL_W),
        .ITC_BODY_CELLS (ITC_BODY_CELLS),
        .IP_RESET       (IP_RESET),
        .RSP_RESET      (RSP_RESET),
        .PSP_RESET      (PSP_RESET)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .itc_q     (itc_q),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .ip_q      (ip_out),
        .w_q       (w_out),
        .pc_q      (pc_out),
        .rsp_q     (rsp_out),
        .psp_q     (psp_out)
    );

    assign mem_rd = ctl.rd;
    assign mem_wr = ctl.wr;

    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start)); // R2

    AST_DONE_AFTER_WORK: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy)); // R9

endmodule

// File: tb/sim_tci_seq.sv
module sim_tci_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'b00;
    logic        itc_mode = 1'b0;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_rd, mem_wr, busy, done;
    logic [15:0] pc_out, ip_out, w_out, rsp_out, psp_out;

    int total = 0;
    int bad = 0;
    int overlap = 0;

    logic [15:0] mem [0:2047];

    always #4 clk = ~clk;

    tci_seq #(
        .CELL_W         (16),
        .ITC_BODY_CELLS (2),
        .IP_RESET       (16'h0400),
        .RSP_RESET      (16'h1000),
        .PSP_RESET      (16'h0F00)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .op        (op),
        .itc_mode  (itc_mode),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .busy      (busy),
        .done      (done),
        .pc_out    (pc_out),
        .ip_out    (ip_out),
        .w_out     (w_out),
        .rsp_out   (rsp_out),
        .psp_out   (psp_out)
    );

    // synchronous memory model: one-cycle read latency
    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr[11:1]] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[11:1]];
    end

    always @(negedge clk) begin
        if (rst_n && mem_rd && mem_wr) overlap++;
    end

    task automatic check(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic put(input int addr, input int val);
        mem[addr[11:1]] = val[15:0];
    endtask

    task automatic clear_mem;
        for (int i = 0; i < 2048; i++) mem[i] = 16'h0000;
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0;
        start = 1'b0;
        itc_mode = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic load_dtc;
        clear_mem();
        put(16'h0400, 16'h0200);
        put(16'h0402, 16'h0500);
        put(16'h0202, 16'h0300);
        put(16'h0204, 16'h0100);
        put(16'h0F00, 16'h0300);
    endtask

    task automatic load_itc;
        clear_mem();
        put(16'h0400, 16'h0200);
        put(16'h0402, 16'h0500);
        put(16'h0200, 16'h0600);
        put(16'h0204, 16'h0300);
        put(16'h0206, 16'h0100);
        put(16'h0300, 16'h0302);
        put(16'h0100, 16'h0102);
        put(16'h0500, 16'h0502);
        put(16'h0F00, 16'h0300);
    endtask

    // returns the number of edges from the sampling edge until done is seen
    task automatic run_op(input logic [1:0] o, input logic mode, output int lat);
        @(negedge clk);
        start = 1'b1;
        op = o;
        itc_mode = mode;
        @(posedge clk);
        lat = 1;
        @(negedge clk);
        start = 1'b0;
        while (!done && lat < 40) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
    endtask

    task automatic check_idle_after(input string tag);
        @(posedge clk);
        @(negedge clk);
        check(tag, "done width", int'(done), 0);
        check("R10", "idle access", int'(mem_rd | mem_wr), 0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        load_dtc();
        repeat (2) @(negedge clk);
        check("R1", "ip in reset", ip_out, 16'h0400);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "ip", ip_out, 16'h0400);
        check("R1", "rsp", rsp_out, 16'h1000);
        check("R1", "psp", psp_out, 16'h0F00);
        check("R1", "w", w_out, 0);
        check("R1", "pc", pc_out, 0);
        check("R1", "done", int'(done), 0);
        check("R1", "mem strobes", int'(mem_rd | mem_wr), 0);
    endtask

    task automatic t_dtc_chain;
        int lat;
        load_dtc();
        do_reset();
        run_op(2'b00, 1'b0, lat);
        check("R9", "dtc next latency", lat, 3);
        check("R3", "dtc next w", w_out, 16'h0200);
        check("R3", "dtc next ip", ip_out, 16'h0402);
        check("R3", "dtc next pc", pc_out, 16'h0200);
        check_idle_after("R9");
        run_op(2'b01, 1'b0, lat);
        check("R9", "dtc enter latency", lat, 4);
        check("R5", "dtc enter rsp", rsp_out, 16'h0FFE);
        check("R5", "dtc pushed ip", mem[11'h7FF], 16'h0402);
        check("R5", "dtc enter w", w_out, 16'h0300);
        check("R5", "dtc enter ip", ip_out, 16'h0204);
        check("R5", "dtc enter pc", pc_out, 16'h0300);
        run_op(2'b00, 1'b0, lat);
        check("R3", "dtc 2nd next pc", pc_out, 16'h0100);
        check("R3", "dtc 2nd next ip", ip_out, 16'h0206);
        run_op(2'b10, 1'b0, lat);
        check("R9", "dtc exit latency", lat, 5);
        check("R6", "dtc exit rsp", rsp_out, 16'h1000);
        check("R6", "dtc exit ip", ip_out, 16'h0404);
        check("R6", "dtc exit w", w_out, 16'h0500);
        check("R6", "dtc exit pc", pc_out, 16'h0500);
        run_op(2'b11, 1'b0, lat);
        check("R9", "dtc exec latency", lat, 3);
        check("R7", "dtc exec w", w_out, 16'h0300);
        check("R7", "dtc exec psp", psp_out, 16'h0F02);
        check("R7", "dtc exec pc", pc_out, 16'h0300);
        check("R7", "dtc exec ip kept", ip_out, 16'h0404);
        check("R7", "dtc exec rsp kept", rsp_out, 16'h1000);
        check_idle_after("R9");
    endtask

    task automatic t_itc_chain;
        int lat;
        load_itc();
        do_reset();
        run_op(2'b00, 1'b1, lat);
        check("R9", "itc next latency", lat, 5);
        check("R4", "itc next w", w_out, 16'h0200);
        check("R4", "itc next ip", ip_out, 16'h0402);
        check("R4", "itc next pc", pc_out, 16'h0600);
        run_op(2'b01, 1'b1, lat);
        check("R9", "itc enter latency", lat, 6);
        check("R5", "itc enter rsp", rsp_out, 16'h0FFE);
        check("R5", "itc pushed ip", mem[11'h7FF], 16'h0402);
        check("R5", "itc enter w", w_out, 16'h0300);
        check("R5", "itc enter ip", ip_out, 16'h0206);
        check("R4", "itc enter pc", pc_out, 16'h0302);
        run_op(2'b00, 1'b1, lat);
        check("R4", "itc 2nd next pc", pc_out, 16'h0102);
        check("R3", "itc 2nd next ip", ip_out, 16'h0208);
        run_op(2'b10, 1'b1, lat);
        check("R9", "itc exit latency", lat, 7);
        check("R6", "itc exit rsp", rsp_out, 16'h1000);
        check("R6", "itc exit ip", ip_out, 16'h0404);
        check("R6", "itc exit pc", pc_out, 16'h0502);
        run_op(2'b11, 1'b1, lat);
        check("R9", "itc exec latency", lat, 5);
        check("R7", "itc exec w", w_out, 16'h0300);
        check("R7", "itc exec psp", psp_out, 16'h0F02);
        check("R4", "itc exec pc", pc_out, 16'h0302);
        check("R7", "itc exec ip kept", ip_out, 16'h0404);
        check_idle_after("R9");
    endtask

    // start, op and mode disturbed while an ENTER is in progress
    task automatic t_busy_ignore;
        int lat;
        load_dtc();
        do_reset();
        run_op(2'b00, 1'b0, lat);
        @(negedge clk);
        start = 1'b1;
        op = 2'b01;
        itc_mode = 1'b0;
        @(posedge clk);
        lat = 1;
        @(negedge clk);
        start = 1'b1;
        op = 2'b10;
        itc_mode = 1'b1;
        @(posedge clk);
        lat++;
        @(negedge clk);
        start = 1'b0;
        itc_mode = 1'b0;
        while (!done && lat < 40) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        check("R2", "busy start latency", lat, 4);
        check("R2", "busy start ip", ip_out, 16'h0204);
        check("R2", "busy start rsp", rsp_out, 16'h0FFE);
        check("R8", "mode change pc", pc_out, 16'h0300);
        check("R8", "mode change w", w_out, 16'h0300);
        check_idle_after("R2");
        check("R2", "no extra op ip", ip_out, 16'h0204);
    endtask

    initial begin
        #(8ns * 20000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_dtc_chain();
        t_itc_chain();
        t_busy_ignore();
        check("R10", "rd/wr overlap", overlap, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule